// File: doc/BRIEF.md
# Dual-Mode Configurable GPIO Port Bank

This block is a bank of 8-bit I/O ports. A processor reaches it through a 256-byte register window, and the window answers only while a dedicated I/O chip-select is asserted. Every pin chooses its own driver. In processor mode, the pin is driven from software-written output-value and direction registers. In logic mode, the pin is driven by an internal programmable-logic output, and a logic-supplied enable term can tristate it. A single port can therefore mix processor pins and logic pins.

Each pad input passes through a two-flop synchronizer. The synchronized level goes to two places: the readable input register and the logic-side input bus. After reset, every pin is in logic mode. Logic mode is the power-up configuration.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every mode, direction and output-value bit is 0 and reads back as 0. A 0 mode bit means logic mode, and a 0 direction bit means input.
- R2: Port p owns byte offsets 4p to 4p+3 of the window, in this order: mode (+0), direction (+1), output value (+2), input level (+3). A write takes effect only when cs_i and wr_i are both high. A write with cs_i low changes nothing.
- R3: When a pin's mode bit is 1 (processor mode), pad_o carries that pin's output-value bit and pad_oe_o carries its direction bit (1 = output).
- R4: When a pin's mode bit is 0 (logic mode), pad_o follows pld_out_i and pad_oe_o follows pld_oe_i for that pin.
- R5: Mode is chosen per pin, so processor pins and logic pins can coexist within one port.
- R6: A read of offset +3 returns the pad level after the two-flop synchronizer, whatever the pin's direction.
- R7: pld_in_o presents each pad level two clock edges after it is applied to pad_i.
- R8: Reads of offsets at or beyond 4 × the number of ports return 0. A write to an input-level offset, or to an unmapped offset, alters no register.
- R9: rdata_o carries the read result in the cycle after a read strobe (cs_i and rd_i high) and is 0 in every other cycle.
- R10: A write to one port leaves every other port's registers and pads unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | I/O window chip-select |
| addr_i | input | 8 | Byte offset within the window |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, one cycle after the strobe |
| pld_out_i | input | 40 | Logic-mode output value per pin |
| pld_oe_i | input | 40 | Logic-mode output enable per pin |
| pld_in_o | output | 40 | Synchronized pad levels to the logic |
| pad_i | input | 40 | Pad input levels |
| pad_o | output | 40 | Pad output values |
| pad_oe_o | output | 40 | Pad output enables |

## Verification
The bench builds the block with its default parameters: five 8-bit ports and a two-stage synchronizer. With five ports, offsets 0 to 19 are mapped and offset 20 upward is unmapped, so the bench can probe both the last mapped register and the first unmapped address. The two-stage setting fixes the pad-to-logic latency at two edges. That lets the bench observe the old value one edge after a pad change and the new value at the second edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned REG_STRIDE = 4;

  typedef enum logic [1:0] {
    REG_MODE = 2'd0,
    REG_DIR  = 2'd1,
    REG_DOUT = 2'd2,
    REG_DIN  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 5,
  parameter int unsigned ADDR_W    = 8,
  localparam int unsigned PIDX_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [PIDX_W-1:0] port_o,
  output reg_sel_e          sel_o
);
  logic [ADDR_W-3:0] upper;

  assign upper  = addr_i[ADDR_W-1:2];
  assign hit_o  = (32'(upper) < NUM_PORTS);
  assign port_o = PIDX_W'(upper);
  assign sel_o  = reg_sel_e'(addr_i[1:0]);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  reg_sel_e          sel_i,
  input  logic [PORT_W-1:0] wdata_i,
  input  logic [PORT_W-1:0] pld_out_i,
  input  logic [PORT_W-1:0] pld_oe_i,
  output logic [PORT_W-1:0] pad_o,
  output logic [PORT_W-1:0] pad_oe_o,
  output logic [PORT_W-1:0] mode_o,
  output logic [PORT_W-1:0] dir_o,
  output logic [PORT_W-1:0] dout_o
);
  logic [PORT_W-1:0] mode_q, dir_q, dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      dir_q  <= '0;
      dout_q <= '0;
    end else if (wr_en_i) begin
      unique case (sel_i)
        REG_MODE: mode_q <= wdata_i;
        REG_DIR:  dir_q  <= wdata_i;
        REG_DOUT: dout_q <= wdata_i;
        default:  ;  // input level is read-only
      endcase
    end
  end

  for (genvar b = 0; b < PORT_W; b++) begin : g_pin
    always_comb begin
      if (mode_q[b]) begin
        pad_o[b]    = dout_q[b];
        pad_oe_o[b] = dir_q[b];
      end else begin
        pad_o[b]    = pld_out_i[b];
        pad_oe_o[b] = pld_oe_i[b];
      end
    end
  end

  assign mode_o = mode_q;
  assign dir_o  = dir_q;
  assign dout_o = dout_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 5,
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PINS       = NUM_PORTS * PORT_W,
  localparam int unsigned PIDX_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [PORT_W-1:0] wdata_i,
  output logic [PORT_W-1:0] rdata_o,
  input  logic [PINS-1:0]   pld_out_i,
  input  logic [PINS-1:0]   pld_oe_i,
  output logic [PINS-1:0]   pld_in_o,
  input  logic [PINS-1:0]   pad_i,
  output logic [PINS-1:0]   pad_o,
  output logic [PINS-1:0]   pad_oe_o
);
  logic              hit;
  logic [PIDX_W-1:0] port_idx;
  reg_sel_e          sel;
  logic [PINS-1:0]   pad_sync;
  logic [PINS-1:0]   mode_all, dir_all, dout_all;
  logic [PORT_W-1:0] rd_mux;

  gpio_addr_dec #(
    .NUM_PORTS(NUM_PORTS),
    .ADDR_W   (ADDR_W)
  ) u_dec (
    .addr_i(addr_i),
    .hit_o (hit),
    .port_o(port_idx),
    .sel_o (sel)
  );

  gpio_sync #(
    .WIDTH (PINS),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (pad_sync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic wr_en;
    assign wr_en = cs_i && wr_i && hit && (32'(port_idx) == p);

    gpio_port #(.PORT_W(PORT_W)) u_port (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en),
      .sel_i    (sel),
      .wdata_i  (wdata_i),
      .pld_out_i(pld_out_i[p*PORT_W +: PORT_W]),
      .pld_oe_i (pld_oe_i[p*PORT_W +: PORT_W]),
      .pad_o    (pad_o[p*PORT_W +: PORT_W]),
      .pad_oe_o (pad_oe_o[p*PORT_W +: PORT_W]),
      .mode_o   (mode_all[p*PORT_W +: PORT_W]),
      .dir_o    (dir_all[p*PORT_W +: PORT_W]),
      .dout_o   (dout_all[p*PORT_W +: PORT_W])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (hit && (32'(port_idx) == p)) begin
        unique case (sel)
          REG_MODE: rd_mux = mode_all[p*PORT_W +: PORT_W];
          REG_DIR:  rd_mux = dir_all[p*PORT_W +: PORT_W];
          REG_DOUT: rd_mux = dout_all[p*PORT_W +: PORT_W];
          REG_DIN:  rd_mux = pad_sync[p*PORT_W +: PORT_W];
          default:  rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          rdata_o <= '0;
    else if (cs_i && rd_i) rdata_o <= rd_mux;
    else                  rdata_o <= '0;
  end

  assign pld_in_o = pad_sync;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int unsigned NUM_PORTS   = 5,
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PINS       = NUM_PORTS * PORT_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [PORT_W-1:0] rdata_o,
  input logic [PINS-1:0]   pad_i,
  input logic [PINS-1:0]   pld_in_o,
  input logic [PINS-1:0]   pad_oe_o,
  input logic [PINS-1:0]   mode_all,
  input logic [PINS-1:0]   dir_all,
  input logic [PINS-1:0]   dout_all
);
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R9: idle cycles give zero read data
  p_rdata_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && rd_i) |=> (rdata_o == '0));

  // R8: unmapped reads give zero
  p_unmapped_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && (32'(addr_i) >= NUM_PORTS * 4)) |=> (rdata_o == '0));

  // R2: registers hold without a selected write
  p_hold_no_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && wr_i) |=> ($stable(mode_all) && $stable(dir_all) && $stable(dout_all)));

  // R6: input-level read of port 0 matches synchronized level
  p_din_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && (32'(addr_i) == 3)) |=> (rdata_o == $past(pld_in_o[PORT_W-1:0])));

  if (SYNC_STAGES == 2) begin : g_lat
    // R7: two-edge pad latency
    p_sync_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q >= 2'd2) |-> (pld_in_o == $past(pad_i, 2)));
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    // R3: processor output pins drive
    p_proc_drive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_all[i] && dir_all[i]) |-> pad_oe_o[i]);
  end
endmodule

bind gpio_bank gpio_bank_chk #(
  .NUM_PORTS  (NUM_PORTS),
  .PORT_W     (PORT_W),
  .ADDR_W     (ADDR_W),
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_i    (cs_i),
  .addr_i  (addr_i),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .rdata_o (rdata_o),
  .pad_i   (pad_i),
  .pld_in_o(pld_in_o),
  .pad_oe_o(pad_oe_o),
  .mode_all(mode_all),
  .dir_all (dir_all),
  .dout_all(dout_all)
);

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
  localparam int NP = 5;
  localparam int PW = 8;
  localparam int PINS = NP * PW;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic [PW-1:0] wdata_i = '0;
  logic [PW-1:0] rdata_o;
  logic [PINS-1:0] pld_out_i = '0, pld_oe_i = '0, pad_i = '0;
  logic [PINS-1:0] pld_in_o, pad_o, pad_oe_o;

  always #2 clk_i = ~clk_i;

  gpio_bank dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .addr_i(addr_i),
    .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pld_out_i(pld_out_i), .pld_oe_i(pld_oe_i), .pld_in_o(pld_in_o),
    .pad_i(pad_i), .pad_o(pad_o), .pad_oe_o(pad_oe_o)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [PW-1:0] exp_q[$];
  string tag_q[$];
  logic rd_fire = 1'b0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: one read result per strobe
  always @(posedge clk_i) rd_fire <= cs_i && rd_i;
  always @(negedge clk_i) begin
    if (rd_fire && exp_q.size() > 0) begin
      logic [PW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, 64'(rdata_o), 64'(e));
    end
  end

  task automatic bus_wr(logic [7:0] a, logic [PW-1:0] d, logic sel = 1'b1);
    @(negedge clk_i);
    cs_i = sel; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    cs_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, logic [PW-1:0] e, string t);
    @(negedge clk_i);
    cs_i = 1'b1; rd_i = 1'b1; addr_i = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk_i);
    cs_i = 1'b0; rd_i = 1'b0;
  endtask

  function automatic logic [PW-1:0] mix(logic [PW-1:0] m, logic [PW-1:0] r, logic [PW-1:0] l);
    return (m & r) | (~m & l);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    pld_out_i = 40'hA5_3C_FF_0F_96;
    pld_oe_i  = 40'h5A_C3_F0_F0_69;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 R4 pads in logic mode", 64'(pad_o), 64'(pld_out_i));
    check("R1 R4 enables in logic mode", 64'(pad_oe_o), 64'(pld_oe_i));
    for (int p = 0; p < NP; p++)
      for (int r = 0; r < 3; r++)
        bus_rd(8'(4*p + r), '0, "R1 reset register");

    // R3: port 0 fully processor mode
    bus_wr(8'h01, 8'h0F);
    bus_wr(8'h02, 8'hA5);
    bus_wr(8'h00, 8'hFF);
    @(negedge clk_i);
    check("R3 port0 pad_o", 64'(pad_o[7:0]), 64'h A5);
    check("R3 port0 pad_oe_o", 64'(pad_oe_o[7:0]), 64'h0F);

    // R5: port 1 mixed
    bus_wr(8'h05, 8'hFF);
    bus_wr(8'h06, 8'h00);
    bus_wr(8'h04, 8'h3C);
    @(negedge clk_i);
    check("R5 port1 pad_o", 64'(pad_o[15:8]), 64'(mix(8'h3C, 8'h00, pld_out_i[15:8])));
    check("R5 port1 pad_oe_o", 64'(pad_oe_o[15:8]), 64'(mix(8'h3C, 8'hFF, pld_oe_i[15:8])));
    check("R10 port2-4 untouched", 64'(pad_o[39:16]), 64'(pld_out_i[39:16]));

    // R4: logic inputs still steer logic pins
    pld_out_i[15:8] = 8'h00;
    pld_oe_i[15:8]  = 8'h00;
    @(negedge clk_i);
    check("R4 port1 logic pins follow", 64'(pad_o[15:8]), 64'(mix(8'h3C, 8'h00, 8'h00)));
    check("R4 port1 logic enables follow", 64'(pad_oe_o[15:8]), 64'(mix(8'h3C, 8'hFF, 8'h00)));

    // R2: write with chip-select low ignored
    bus_wr(8'h08, 8'hFF, 1'b0);
    bus_rd(8'h08, 8'h00, "R2 cs low write ignored");
    @(negedge clk_i);
    check("R2 port2 pads unchanged", 64'(pad_o[23:16]), 64'(pld_out_i[23:16]));

    // R8: input-level and unmapped writes ignored
    bus_wr(8'h0B, 8'hFF);
    bus_rd(8'h0B, 8'h00, "R8 din write ignored");
    bus_wr(8'h14, 8'hFF);
    bus_rd(8'h14, 8'h00, "R8 unmapped read zero");
    bus_rd(8'hFF, 8'h00, "R8 top offset zero");
    for (int r = 0; r < 3; r++) bus_rd(8'(16 + r), '0, "R8 port4 unchanged");

    // R7: synchronizer latency
    @(negedge clk_i);
    pad_i[31:24] = 8'h5A;
    @(negedge clk_i);
    check("R7 one edge still old", 64'(pld_in_o[31:24]), 64'h00);
    @(negedge clk_i);
    check("R7 two edges new", 64'(pld_in_o[31:24]), 64'h5A);

    // R6: input level readable regardless of direction
    bus_rd(8'h0F, 8'h5A, "R6 port3 din");
    pad_i[7:0] = 8'hC3;
    repeat (3) @(negedge clk_i);
    bus_rd(8'h03, 8'hC3, "R6 port0 din with outputs");

    // R2 / R10 readback
    bus_rd(8'h00, 8'hFF, "R2 port0 mode");
    bus_rd(8'h01, 8'h0F, "R2 port0 dir");
    bus_rd(8'h02, 8'hA5, "R2 port0 dout");
    bus_rd(8'h04, 8'h3C, "R10 port1 mode");
    bus_rd(8'h05, 8'hFF, "R10 port1 dir");
    bus_wr(8'h02, 8'h5A);
    @(negedge clk_i);
    check("R10 port1 pads after port0 write", 64'(pad_o[15:8]), 64'(mix(8'h3C, 8'h00, 8'h00)));
    check("R3 port0 new dout", 64'(pad_o[7:0]), 64'h5A);

    // R9: idle read bus
    @(negedge clk_i);
    @(negedge clk_i);
    check("R9 rdata idle zero", 64'(rdata_o), 64'h00);
    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule